// File: doc/BRIEF.md
# Stalled-Rotor Supervisor for a Two-Phase Fan

This block watches the Hall sensor of a two-phase brushless fan and decides whether the phase drive may run. While Hall transitions keep arriving, the drive is permitted continuously. If no transition arrives within a detection window, the rotor is treated as stalled.

On a stall the block raises a lock flag and enters a protective retry cycle. It permits the drive for a short burst and then blocks it for a much longer wait. This cycle repeats until the Hall sensor moves again. The nominal burst-to-wait ratio is 1:12. All periods are counts of the system clock and are set by parameters.

The block also provides two outputs:
- an inverted copy of the Hall signal, which serves as a speed signal;
- one open-collector status pin. Its meaning is chosen by a parameter: combined speed-and-lock, lock only, or speed only.

An external PWM phase driver uses `drive_permit` as its gate.

Top module: `rotor_guard`

## Requirements
- R1: While `rst` is high, `lock_flag` and `drive_permit` are 0. After `rst` falls, with the Hall input steady, `lock_flag` rises exactly DETECT_CYC clock cycles later.
- R2: Every Hall change, rising or falling, restarts the detection window. With toggles spaced closer than the window, `lock_flag` stays 0. After the last Hall change, `lock_flag` rises DETECT_CYC+3 cycles later. The 3 extra cycles are two synchroniser flops plus the edge register.
- R3: When `lock_flag` rises, `drive_permit` stays 1 for exactly BURST_CYC cycles.
- R4: After each burst, `drive_permit` is 0 for exactly WAIT_CYC cycles. Another burst follows, and the burst/wait cycle repeats while the Hall input is steady.
- R5: Once raised, `lock_flag` stays 1 through the whole retry cycle, whether the Hall level is 0 or 1. Any Hall change clears it 3 cycles after the change, and `drive_permit` is then 1.
- R6: `speed_out` is the inverse of `hall_in`, delayed by 2 clock cycles.
- R7: `tach_pd_n` is an active-low pull-down enable, so 1 means the pin floats high. With TACH_MODE = TACH_COMBINED, it equals `speed_out` while unlocked and is 1 while locked.
- R8: With TACH_MODE = TACH_LOCK_ONLY, `tach_pd_n` is 0 while unlocked and 1 while locked.
- R9: With TACH_MODE = TACH_SPEED_ONLY, `tach_pd_n` always equals `speed_out`, including while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hall_in | input | 1 | Asynchronous Hall sensor level |
| speed_out | output | 1 | Inverted, synchronised Hall level |
| tach_pd_n | output | 1 | Active-low pull-down enable for the open-collector status pin |
| lock_flag | output | 1 | High while a stall is being handled |
| drive_permit | output | 1 | Gate for the external phase driver |

## Verification
Suppose the window counter or the state register takes a wrong value. It shows at the ports as a `lock_flag` rise on the wrong cycle, or as a `drive_permit` high or low run of the wrong length. It therefore appears at the next rise of `lock_flag` or at the first retry period. A missed edge on the Hall path shows as a lock while the input is toggling, or as a lock that is not released within 3 cycles of a Hall change. A wrong output-mode selection shows at once on `tach_pd_n` in the unlocked state, or on the first cycle of a lock.

// File: rtl/rotor_guard_pkg.sv
package rotor_guard_pkg;

    typedef enum logic [1:0] {
        SUP_RUN   = 2'd0,
        SUP_BURST = 2'd1,
        SUP_WAIT  = 2'd2
    } sup_state_e;

    typedef enum logic [1:0] {
        TACH_COMBINED   = 2'd0,
        TACH_LOCK_ONLY  = 2'd1,
        TACH_SPEED_ONLY = 2'd2
    } tach_mode_e;

    typedef struct packed {
        logic level;
        logic edge_seen;
    } hall_sample_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned ctr_width(input int unsigned span);
        return (span < 2) ? 1 : $clog2(span);
    endfunction

endpackage

// File: rtl/rotor_guard_hall_sync.sv
module rotor_guard_hall_sync
    import rotor_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         hall_raw,
    output hall_sample_t smp
);
    // [0] and [1] form the synchroniser, [2] holds the previous synchronised level
    logic [2:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) shift_q <= '0;
        else     shift_q <= {shift_q[1:0], hall_raw};
    end

    assign smp.level     = shift_q[1];
    assign smp.edge_seen = shift_q[1] ^ shift_q[2];

endmodule

// File: rtl/rotor_guard_stall_fsm.sv
module rotor_guard_stall_fsm
    import rotor_guard_pkg::*;
#(
    parameter int unsigned DETECT_CYC = 100_000_000,
    parameter int unsigned BURST_CYC  = 33_000_000,
    parameter int unsigned WAIT_CYC   = 396_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hall_edge,
    output sup_state_e state
);
    localparam int unsigned CW = ctr_width(max3(DETECT_CYC, BURST_CYC, WAIT_CYC));
    localparam logic [CW-1:0] DET_LAST   = CW'(DETECT_CYC - 1);
    localparam logic [CW-1:0] BURST_LAST = CW'(BURST_CYC - 1);
    localparam logic [CW-1:0] WAIT_LAST  = CW'(WAIT_CYC - 1);

    sup_state_e    st_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SUP_RUN;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                SUP_RUN: begin
                    if (hall_edge) begin
                        cnt_q <= '0;
                    end else if (cnt_q == DET_LAST) begin
                        st_q  <= SUP_BURST;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SUP_BURST: begin
                    if (hall_edge) begin
                        st_q  <= SUP_RUN;
                        cnt_q <= '0;
                    end else if (cnt_q == BURST_LAST) begin
                        st_q  <= SUP_WAIT;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SUP_WAIT: begin
                    if (hall_edge) begin
                        st_q  <= SUP_RUN;
                        cnt_q <= '0;
                    end else if (cnt_q == WAIT_LAST) begin
                        st_q  <= SUP_BURST;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    st_q  <= SUP_RUN;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign state = st_q;

    // R2: the window counter never runs past its limit while running
    a_r2_window_bound: assert property (@(posedge clk) disable iff (rst)
        (st_q == SUP_RUN) |-> (cnt_q <= DET_LAST));

    // R1: a lock is entered only when the window has fully expired
    a_r1_lock_entry: assert property (@(posedge clk) disable iff (rst)
        (st_q == SUP_BURST && $past(st_q) == SUP_RUN) |-> ($past(cnt_q) == DET_LAST));

    // R3: a burst ends only after its full length
    a_r3_burst_len: assert property (@(posedge clk) disable iff (rst)
        (st_q == SUP_WAIT && $past(st_q) == SUP_BURST) |-> ($past(cnt_q) == BURST_LAST));

    // R4: a wait ends only after its full length
    a_r4_wait_len: assert property (@(posedge clk) disable iff (rst)
        (st_q == SUP_BURST && $past(st_q) == SUP_WAIT) |-> ($past(cnt_q) == WAIT_LAST));

endmodule

// File: rtl/rotor_guard_tach_out.sv
module rotor_guard_tach_out
    import rotor_guard_pkg::*;
#(
    parameter tach_mode_e TACH_MODE = TACH_COMBINED
) (
    input  logic hall_level,
    input  logic locked,
    output logic speed_n,
    output logic pin_level
);
    assign speed_n = ~hall_level;

    generate
        if (TACH_MODE == TACH_LOCK_ONLY) begin : g_lock_only
            assign pin_level = locked;
        end else if (TACH_MODE == TACH_SPEED_ONLY) begin : g_speed_only
            assign pin_level = ~hall_level;
        end else begin : g_combined
            assign pin_level = locked | ~hall_level;
        end
    endgenerate

endmodule

// File: rtl/rotor_guard.sv
module rotor_guard
    import rotor_guard_pkg::*;
#(
    parameter int unsigned DETECT_CYC = 100_000_000,
    parameter int unsigned BURST_CYC  = 33_000_000,
    parameter int unsigned WAIT_CYC   = 396_000_000,
    parameter tach_mode_e  TACH_MODE  = TACH_COMBINED
) (
    input  logic clk,
    input  logic rst,
    input  logic hall_in,
    output logic speed_out,
    output logic tach_pd_n,
    output logic lock_flag,
    output logic drive_permit
);
    hall_sample_t hall_s;
    sup_state_e   sup_st;

    rotor_guard_hall_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .hall_raw (hall_in),
        .smp      (hall_s)
    );

    rotor_guard_stall_fsm #(
        .DETECT_CYC (DETECT_CYC),
        .BURST_CYC  (BURST_CYC),
        .WAIT_CYC   (WAIT_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .hall_edge (hall_s.edge_seen),
        .state     (sup_st)
    );

    rotor_guard_tach_out #(
        .TACH_MODE (TACH_MODE)
    ) u_tach (
        .hall_level (hall_s.level),
        .locked     (lock_flag),
        .speed_n    (speed_out),
        .pin_level  (tach_pd_n)
    );

    assign lock_flag    = (sup_st != SUP_RUN);
    assign drive_permit = ~rst & (sup_st != SUP_WAIT);

    // R5: a Hall change during a lock releases it on the next cycle with drive allowed
    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        (hall_s.edge_seen && lock_flag) |=> (!lock_flag && drive_permit));

    // R7, R8: in the modes that report a lock, the pin floats high while locked
    a_r7_lock_pin: assert property (@(posedge clk) disable iff (rst)
        (lock_flag && TACH_MODE != TACH_SPEED_ONLY) |-> tach_pd_n);

    // R1: unlocked running always allows the drive
    a_r1_run_permit: assert property (@(posedge clk) disable iff (rst)
        (!lock_flag) |-> drive_permit);

endmodule

// File: tb/rotor_guard_bench.sv
module rotor_guard_bench;
    import rotor_guard_pkg::*;

    localparam int unsigned DET   = 40;
    localparam int unsigned BURST = 5;
    localparam int unsigned WAIT  = 60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hall = 1'b0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    logic spd_c, pin_c, lock_c, perm_c;
    logic spd_l, pin_l, lock_l, perm_l;
    logic spd_s, pin_s, lock_s, perm_s;

    always #5 clk = ~clk;

    rotor_guard #(.DETECT_CYC(DET), .BURST_CYC(BURST), .WAIT_CYC(WAIT),
                  .TACH_MODE(TACH_COMBINED)) u_rotor_guard (
        .clk(clk), .rst(rst), .hall_in(hall), .speed_out(spd_c),
        .tach_pd_n(pin_c), .lock_flag(lock_c), .drive_permit(perm_c));

    rotor_guard #(.DETECT_CYC(DET), .BURST_CYC(BURST), .WAIT_CYC(WAIT),
                  .TACH_MODE(TACH_LOCK_ONLY)) u_rotor_guard_lk (
        .clk(clk), .rst(rst), .hall_in(hall), .speed_out(spd_l),
        .tach_pd_n(pin_l), .lock_flag(lock_l), .drive_permit(perm_l));

    rotor_guard #(.DETECT_CYC(DET), .BURST_CYC(BURST), .WAIT_CYC(WAIT),
                  .TACH_MODE(TACH_SPEED_ONLY)) u_rotor_guard_sp (
        .clk(clk), .rst(rst), .hall_in(hall), .speed_out(spd_s),
        .tach_pd_n(pin_s), .lock_flag(lock_s), .drive_permit(perm_s));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // counts rising clock edges until lock_flag is seen high at a falling edge
    task automatic cycles_to_lock(output int n);
        n = 0;
        while (n < 5000) begin
            @(negedge clk);
            n++;
            if (lock_c) break;
        end
    endtask

    task automatic t_reset;
        int n;
        rst = 1'b1; hall = 1'b0;
        step(4);
        chk(lock_c == 1'b0, "R1 lock in reset", lock_c, 0);
        chk(perm_c == 1'b0, "R1 permit in reset", perm_c, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(perm_c == 1'b1, "R1 permit after reset", perm_c, 1);
        n = 1;
        while (!lock_c && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(n == DET, "R1 detection from reset", n, DET);
    endtask

    task automatic t_detect(input logic final_level);
        int n;
        hall = ~hall;
        step(4);
        chk(lock_c == 1'b0, "R5 released by edge", lock_c, 0);
        for (int i = 0; i < 6; i++) begin
            step(DET - 10);
            hall = ~hall;
        end
        step(2);
        chk(lock_c == 1'b0, "R2 no lock while toggling", lock_c, 0);
        if (hall == final_level) begin
            step(DET - 10);
            hall = ~hall;
            step(DET - 10);
        end
        hall = final_level;
        cycles_to_lock(n);
        chk(n == DET + 3, "R2 detection after last edge", n, DET + 3);
        chk(pin_c == 1'b1, "R7 combined pin while locked", pin_c, 1);
        chk(pin_l == 1'b1, "R8 lock-only pin while locked", pin_l, 1);
        chk(pin_s == ~final_level, "R9 speed-only pin while locked", pin_s, ~final_level);
    endtask

    task automatic t_retry;
        int n;
        bit lock_ok;
        n = 0; lock_ok = 1'b1;
        while (perm_c && n < 5000) begin
            n++;
            lock_ok &= lock_c;
            @(negedge clk);
        end
        chk(n == BURST, "R3 burst length", n, BURST);
        n = 0;
        while (!perm_c && n < 5000) begin
            n++;
            lock_ok &= lock_c;
            @(negedge clk);
        end
        chk(n == WAIT, "R4 wait length", n, WAIT);
        chk(perm_c == 1'b1, "R4 second burst", perm_c, 1);
        chk(lock_ok, "R5 lock held through retry", lock_ok, 1);
    endtask

    task automatic t_release;
        int n;
        hall = ~hall;
        n = 0;
        while (lock_c && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == 3, "R5 release latency", n, 3);
        chk(perm_c == 1'b1, "R5 permit after release", perm_c, 1);
    endtask

    task automatic t_modes(input logic lvl);
        hall = lvl;
        step(3);
        chk(pin_c == ~lvl, "R7 combined pin running", pin_c, ~lvl);
        chk(pin_l == 1'b0, "R8 lock-only pin running", pin_l, 0);
        chk(pin_s == ~lvl, "R9 speed-only pin running", pin_s, ~lvl);
        hall = ~lvl;
        step(1);
        chk(spd_c == ~lvl, "R6 speed holds after one cycle", spd_c, ~lvl);
        step(1);
        chk(spd_c == lvl, "R6 speed after two cycles", spd_c, lvl);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_detect(1'b1);
        t_retry();
        t_release();
        t_detect(1'b0);
        t_retry();
        t_release();
        t_modes(1'b1);
        t_modes(1'b0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule